// File: doc/BRIEF.md
# AHB Slave Response Protocol Monitor

This block watches the control side of a single AHB slave port and raises a flag when the slave's responses break the transfer rules. It sees the request that the master presents to the slave: select, incoming ready and transfer type. It also sees what the slave drives back: its own ready and its two-bit response. Address and data buses are not inputs. A small state machine follows the data phase that each accepted address phase opens. It counts wait cycles, checks the shape of error responses and checks the response given to non-data transfers.

Two terminal states stop the checking. A violation state holds the flag, and the reason code of the first rule broken, until a synchronous clear or a reset. The checking can also stop because the slave answers a data phase with a RETRY or SPLIT response. These responses are outside the monitor's scope, so the monitor parks in a don't-care state and reports nothing more until it is cleared. The block is meant to be dropped next to a slave in simulation or emulation, or kept in silicon as a bring-up aid.

Top module: `ahb_resp_monitor`

## Requirements
- R1: After reset, viol_o is 0 and reason_o is 0.
- R2: Encodings. trans_i: IDLE=00, BUSY=01, NONSEQ=10, SEQ=11. resp_i: OKAY=00, ERROR=01, RETRY=10, SPLIT=11. An address phase is accepted on a clock edge where sel_i=1 and ready_in_i=1. The data phase of that transfer is the next cycle, and it lasts until slave_ready_i=1. A NONSEQ or SEQ data phase that sees up to MAX_WAIT (16) consecutive OKAY cycles with slave_ready_i=0, and then completes with OKAY, raises no violation.
- R3: A NONSEQ or SEQ data phase can show an OKAY wait cycle while MAX_WAIT wait cycles have already been counted, which is wait cycle 17 at the default. viol_o then rises at the edge that samples that cycle, with reason_o=1 (wait overflow).
- R4: An ERROR response must take two cycles. In the first, slave_ready_i=0 and resp_i=ERROR. In the second, slave_ready_i=1 and resp_i=ERROR. Two violations give reason_o=3 (bad error shape): ERROR with slave_ready_i=1 in the first cycle, and a second cycle that is not ready with ERROR.
- R5: An IDLE or BUSY data phase must be answered in its first cycle with slave_ready_i=1 and OKAY. Any other answer gives reason_o=4.
- R6: An IDLE or BUSY transfer can be accepted in the final cycle of an ERROR response. Its data phase must then get slave_ready_i=1 and OKAY. Any other answer gives reason_o=2 (no OKAY after error).
- R7: Once viol_o is 1, it stays 1 and reason_o keeps the code of the first violation until clear_i or reset, whatever the later inputs.
- R8: A RETRY or SPLIT response seen in any data phase moves the monitor to a don't-care state. From there, no violation is reported until clear_i or reset.
- R9: clear_i=1 at an edge returns the monitor to the no-transfer state. It sets viol_o and reason_o to 0 and resets the wait count.
- R10: A response is ignored when no data phase is open. This covers cycles after an address phase with sel_i=0 or ready_in_i=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Synchronous return to the no-transfer state |
| sel_i | input | 1 | Slave select from the decoder |
| ready_in_i | input | 1 | Bus ready seen by the slave |
| trans_i | input | 2 | Transfer type of the current address phase |
| slave_ready_i | input | 1 | Ready driven by the slave |
| resp_i | input | 2 | Response driven by the slave |
| viol_o | output | 1 | Sticky violation flag |
| reason_o | output | 3 | Code of the first broken rule, 0 when none |

## Verification
The hardest case to reach from the ports is the boundary between 16 and 17 consecutive waits. The count must also really restart after a clear that lands in the middle of a wait run. The bench builds both by holding an open data phase with OKAY and low ready for an exact number of cycles, once after a mid-run clear. The post-error rule is also reached only through one narrow pattern: a complete two-cycle ERROR whose final cycle also accepts an IDLE address phase. The directed sequences set up that overlap deliberately.

// File: rtl/ahb_mon_pkg.sv
package ahb_mon_pkg;
  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_BUSY   = 2'b01;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;

  localparam logic [1:0] RS_OKAY  = 2'b00;
  localparam logic [1:0] RS_ERROR = 2'b01;

  typedef enum logic [2:0] {
    ST_ORIG,
    ST_CTL,
    ST_DATA,
    ST_ERR2,
    ST_VIO,
    ST_DC
  } mon_state_e;

  typedef enum logic [2:0] {
    RC_NONE     = 3'd0,
    RC_WAIT_OVF = 3'd1,
    RC_NO_OKAY  = 3'd2,
    RC_ERR_SHP  = 3'd3,
    RC_CTL_RESP = 3'd4
  } reason_e;
endpackage

// File: rtl/ahb_mon_decode.sv
module ahb_mon_decode
  import ahb_mon_pkg::*;
(
  input  logic       sel_i,
  input  logic       ready_in_i,
  input  logic [1:0] trans_i,
  input  logic       slave_ready_i,
  input  logic [1:0] resp_i,
  output logic       start_data_o,
  output logic       start_ctl_o,
  output logic       okay_done_o,
  output logic       okay_wait_o,
  output logic       err_first_o,
  output logic       err_last_o,
  output logic       abort_o
);
  logic accept;

  assign accept       = sel_i & ready_in_i;
  assign start_data_o = accept & ((trans_i == TR_NONSEQ) | (trans_i == TR_SEQ));
  assign start_ctl_o  = accept & ((trans_i == TR_IDLE) | (trans_i == TR_BUSY));
  assign okay_done_o  = (resp_i == RS_OKAY) & slave_ready_i;
  assign okay_wait_o  = (resp_i == RS_OKAY) & ~slave_ready_i;
  assign err_first_o  = (resp_i == RS_ERROR) & ~slave_ready_i;
  assign err_last_o   = (resp_i == RS_ERROR) & slave_ready_i;
  assign abort_o      = resp_i[1];
endmodule

// File: rtl/ahb_mon_wait_ctr.sv
module ahb_mon_wait_ctr #(
  parameter int unsigned MAX_WAIT = 16,
  localparam int unsigned CW = $clog2(MAX_WAIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wait_i,
  output logic at_max_o
);
  localparam logic [CW-1:0] CMAX = CW'(MAX_WAIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!wait_i)         cnt_q <= '0;
    else if (cnt_q != CMAX)   cnt_q <= cnt_q + 1'b1;
  end

  assign at_max_o = (cnt_q == CMAX);

  // R3
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_i && !at_max_o |=> cnt_q == $past(cnt_q) + 1'b1);

  // R9
  cnt_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wait_i |=> cnt_q == '0);
endmodule

// File: rtl/ahb_resp_monitor.sv
module ahb_resp_monitor
  import ahb_mon_pkg::*;
#(
  parameter int unsigned MAX_WAIT = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       sel_i,
  input  logic       ready_in_i,
  input  logic [1:0] trans_i,
  input  logic       slave_ready_i,
  input  logic [1:0] resp_i,
  output logic       viol_o,
  output logic [2:0] reason_o
);
  mon_state_e state_q, state_d;
  reason_e    reason_q, reason_d;
  logic       post_err_q, post_err_d;

  logic start_data, start_ctl, okay_done, okay_wait, err_first, err_last, abort;
  logic wait_cyc, wait_full;

  ahb_mon_decode u_dec (
    .sel_i        (sel_i),
    .ready_in_i   (ready_in_i),
    .trans_i      (trans_i),
    .slave_ready_i(slave_ready_i),
    .resp_i       (resp_i),
    .start_data_o (start_data),
    .start_ctl_o  (start_ctl),
    .okay_done_o  (okay_done),
    .okay_wait_o  (okay_wait),
    .err_first_o  (err_first),
    .err_last_o   (err_last),
    .abort_o      (abort)
  );

  assign wait_cyc = ~clear_i & (state_q == ST_DATA) & okay_wait & ~wait_full;

  ahb_mon_wait_ctr #(.MAX_WAIT(MAX_WAIT)) u_wait (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wait_i  (wait_cyc),
    .at_max_o(wait_full)
  );

  function automatic mon_state_e next_phase(input logic sd, input logic sc);
    if (sd)      return ST_DATA;
    else if (sc) return ST_CTL;
    else         return ST_ORIG;
  endfunction

  always_comb begin
    state_d    = state_q;
    reason_d   = reason_q;
    post_err_d = 1'b0;
    unique case (state_q)
      ST_ORIG: state_d = next_phase(start_data, start_ctl);
      ST_CTL: begin
        if (abort) state_d = ST_DC;
        else if (okay_done) state_d = next_phase(start_data, start_ctl);
        else begin
          state_d  = ST_VIO;
          reason_d = post_err_q ? RC_NO_OKAY : RC_CTL_RESP;
        end
      end
      ST_DATA: begin
        if (abort) state_d = ST_DC;
        else if (okay_done) state_d = next_phase(start_data, start_ctl);
        else if (okay_wait) begin
          if (wait_full) begin
            state_d  = ST_VIO;
            reason_d = RC_WAIT_OVF;
          end
        end else if (err_first) state_d = ST_ERR2;
        else begin
          state_d  = ST_VIO;
          reason_d = RC_ERR_SHP;
        end
      end
      ST_ERR2: begin
        if (abort) state_d = ST_DC;
        else if (err_last) begin
          state_d    = next_phase(start_data, start_ctl);
          post_err_d = 1'b1;
        end else begin
          state_d  = ST_VIO;
          reason_d = RC_ERR_SHP;
        end
      end
      ST_VIO: state_d = ST_VIO;
      ST_DC:  state_d = ST_DC;
      default: state_d = ST_ORIG;
    endcase
    if (clear_i) begin
      state_d    = ST_ORIG;
      reason_d   = RC_NONE;
      post_err_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_ORIG;
      reason_q   <= RC_NONE;
      post_err_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      reason_q   <= reason_d;
      post_err_q <= post_err_d;
    end
  end

  assign viol_o   = (state_q == ST_VIO);
  assign reason_o = reason_q;

  // R7
  viol_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o && !clear_i |=> viol_o && $stable(reason_o));

  // R7
  viol_has_reason_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> reason_o != 3'd0);

  // R9
  clear_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !viol_o && reason_o == 3'd0);

  // R8
  dc_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DC && !clear_i |=> !viol_o);

  // R10
  orig_no_viol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_ORIG |=> !viol_o);

  // R3
  wait_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i && state_q == ST_DATA && okay_wait && wait_full |=> viol_o && reason_o == 3'd1);
endmodule

// File: tb/tb_ahb_resp_monitor.sv
module tb_ahb_resp_monitor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear = 1'b0;
  logic       sel = 1'b0, rin = 1'b0, srdy = 1'b1;
  logic [1:0] trans = 2'b00, resp = 2'b00;
  logic       viol;
  logic [2:0] reason;
  int         total = 0, bad = 0;

  always #4 clk = ~clk;

  ahb_resp_monitor dut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .sel_i(sel), .ready_in_i(rin),
    .trans_i(trans), .slave_ready_i(srdy), .resp_i(resp), .viol_o(viol), .reason_o(reason)
  );

  // {sel, rin, trans, srdy, resp, exp_viol, exp_reason}
  localparam int NV = 14;
  localparam logic [10:0] VEC [NV] = '{
    {1'b1, 1'b1, 2'b10, 1'b1, 2'b00, 1'b0, 3'd0}, // open NONSEQ (R2)
    {1'b1, 1'b1, 2'b00, 1'b1, 2'b00, 1'b0, 3'd0}, // data OK, open IDLE
    {1'b1, 1'b1, 2'b01, 1'b1, 2'b00, 1'b0, 3'd0}, // IDLE OK, open BUSY (R5)
    {1'b1, 1'b1, 2'b10, 1'b1, 2'b00, 1'b0, 3'd0}, // BUSY OK, open NONSEQ
    {1'b0, 1'b0, 2'b00, 1'b0, 2'b01, 1'b0, 3'd0}, // ERROR cycle 1 (R4)
    {1'b1, 1'b1, 2'b00, 1'b1, 2'b01, 1'b0, 3'd0}, // ERROR cycle 2, open IDLE
    {1'b0, 1'b0, 2'b00, 1'b1, 2'b00, 1'b0, 3'd0}, // post-error IDLE OK (R6)
    {1'b0, 1'b1, 2'b10, 1'b1, 2'b01, 1'b0, 3'd0}, // no phase: ignored (R10)
    {1'b1, 1'b0, 2'b10, 1'b1, 2'b00, 1'b0, 3'd0}, // not accepted (R10)
    {1'b0, 1'b0, 2'b00, 1'b1, 2'b01, 1'b0, 3'd0}, // still no phase (R10)
    {1'b1, 1'b1, 2'b11, 1'b1, 2'b00, 1'b0, 3'd0}, // open SEQ
    {1'b0, 1'b0, 2'b00, 1'b0, 2'b01, 1'b0, 3'd0}, // ERROR cycle 1
    {1'b0, 1'b0, 2'b00, 1'b1, 2'b00, 1'b1, 3'd3}, // bad second cycle (R4)
    {1'b1, 1'b1, 2'b00, 1'b0, 2'b00, 1'b1, 3'd3}  // sticky (R7)
  };

  task automatic drive(input logic s, input logic r, input logic [1:0] t,
                       input logic sr, input logic [1:0] rs);
    @(negedge clk);
    sel = s; rin = r; trans = t; srdy = sr; resp = rs;
    @(posedge clk);
    #1;
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear = 1'b1; sel = 1'b0; rin = 1'b0; srdy = 1'b1; resp = 2'b00;
    @(posedge clk);
    #1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic check(input logic ev, input logic [2:0] er, input string req);
    total++;
    if (viol !== ev || reason !== er) begin
      bad++;
      $display("FAIL %s: viol=%0b reason=%0d expected viol=%0b reason=%0d",
               req, viol, reason, ev, er);
    end
  endtask

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog: viol=%0b reason=%0d expected run to finish", viol, reason);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(1'b0, 3'd0, "R1");
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][10], VEC[i][9], VEC[i][8:7], VEC[i][6], VEC[i][5:4]);
      check(VEC[i][3], VEC[i][2:0], $sformatf("R2/R4/R5/R6/R7/R10 vec%0d", i));
    end

    do_clear();
    #1 check(1'b0, 3'd0, "R9 clear");

    // R2: exactly 16 waits then OKAY
    drive(1, 1, 2'b10, 1, 2'b00);
    for (int i = 0; i < 16; i++) drive(0, 0, 2'b00, 0, 2'b00);
    check(1'b0, 3'd0, "R2 16 waits");
    drive(0, 0, 2'b00, 1, 2'b00);
    check(1'b0, 3'd0, "R2 complete");

    // R3: 17th wait overflows
    drive(1, 1, 2'b11, 1, 2'b00);
    for (int i = 0; i < 16; i++) drive(0, 0, 2'b00, 0, 2'b00);
    check(1'b0, 3'd0, "R3 before overflow");
    drive(0, 0, 2'b00, 0, 2'b00);
    check(1'b1, 3'd1, "R3 overflow");
    drive(0, 0, 2'b00, 1, 2'b01);
    check(1'b1, 3'd1, "R7 first reason kept");

    // R9: clear mid-run restarts the wait count
    do_clear();
    drive(1, 1, 2'b10, 1, 2'b00);
    for (int i = 0; i < 10; i++) drive(0, 0, 2'b00, 0, 2'b00);
    do_clear();
    #1 check(1'b0, 3'd0, "R9 mid-wait clear");
    drive(1, 1, 2'b10, 1, 2'b00);
    for (int i = 0; i < 16; i++) drive(0, 0, 2'b00, 0, 2'b00);
    drive(0, 0, 2'b00, 1, 2'b00);
    check(1'b0, 3'd0, "R9 count restarted");

    // R4: one-cycle ERROR
    drive(1, 1, 2'b10, 1, 2'b00);
    drive(0, 0, 2'b00, 1, 2'b01);
    check(1'b1, 3'd3, "R4 one-cycle error");

    // R5: IDLE answered with a wait
    do_clear();
    drive(1, 1, 2'b00, 1, 2'b00);
    drive(0, 0, 2'b00, 0, 2'b00);
    check(1'b1, 3'd4, "R5 idle wait");

    // R5: BUSY answered with ERROR
    do_clear();
    drive(1, 1, 2'b01, 1, 2'b00);
    drive(0, 0, 2'b00, 1, 2'b01);
    check(1'b1, 3'd4, "R5 busy error");

    // R6: IDLE after ERROR answered with ERROR
    do_clear();
    drive(1, 1, 2'b10, 1, 2'b00);
    drive(0, 0, 2'b00, 0, 2'b01);
    drive(1, 1, 2'b00, 1, 2'b01);
    check(1'b0, 3'd0, "R6 error accepted");
    drive(0, 0, 2'b00, 0, 2'b01);
    check(1'b1, 3'd2, "R6 no okay after error");
    drive(1, 1, 2'b10, 1, 2'b00);
    drive(0, 0, 2'b00, 1, 2'b01);
    check(1'b1, 3'd2, "R7 reason held");

    // R8: RETRY parks monitor, later errors ignored
    do_clear();
    drive(1, 1, 2'b10, 1, 2'b00);
    drive(0, 0, 2'b00, 0, 2'b10);
    check(1'b0, 3'd0, "R8 retry");
    drive(1, 1, 2'b00, 1, 2'b00);
    drive(0, 0, 2'b00, 1, 2'b01);
    check(1'b0, 3'd0, "R8 dont-care quiet");
    do_clear();
    drive(1, 1, 2'b10, 1, 2'b00);
    drive(0, 0, 2'b00, 1, 2'b01);
    check(1'b1, 3'd3, "R8 checking resumes after clear");

    // R1: async reset mid-violation
    @(negedge clk) rst_n = 1'b0;
    #1 check(1'b0, 3'd0, "R1 reset");
    @(negedge clk) rst_n = 1'b1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule